// File: doc/BRIEF.md
# Flat Page Table Walker

This block translates a 32-bit virtual address into a 30-bit physical address. The page table is flat and lives in main memory. Pages are 4 KB, so the low 12 address bits are the page offset and the upper 20 bits are the virtual page number. The table holds one 32-bit entry per virtual page and is indexed directly by that number. The table's base address comes from the current process's base register. That value is presented on an input and captured when a request is taken.

For each request the walker issues a single word read to memory through a valid/ready read port and waits for the returned entry. It then answers with one of three results:

- a physical address;
- a page fault, which carries the entry's disk-location field;
- a protection fault, when a write hits a page that is not writable.

Only one translation is in flight at a time. The answer is held until the requester takes it. Fault handling, disk transfers and page replacement belong to software.

Top module: `pt_walker`

## Requirements
- R1: `reqReady` is high only while no translation is in flight. A request is taken on a cycle where `reqValid` and `reqReady` are both high, and `reqReady` stays low from the next cycle until the response has been taken.
- R2: Each taken request produces exactly one memory read. Its address is `tableBase + vaddr[31:12]*4`, using the `tableBase` value sampled when the request was taken. Later changes to `tableBase` do not affect it.
- R3: If entry bit 31 (valid) is 1 and no protection fault applies, `rspPaddr` equals `{entry[17:0], vaddr[11:0]}` and both fault flags are 0.
- R4: If entry bit 31 is 0, `rspPageFault` is 1, `rspPaddr` is 0, `rspDiskLoc` equals `entry[17:0]` and `rspProtFault` is 0, whatever the access type and bit 30.
- R5: A write (`reqWrite`=1) to a valid entry whose bit 30 (writable) is 0 gives `rspProtFault`=1, `rspPageFault`=0, `rspPaddr`=0 and `rspDiskLoc`=0. A read of the same kind of entry translates normally.
- R6: Once `rspValid` is high it stays high, with every response field unchanged, until a cycle where `rspReady` is high. It drops on the following cycle.
- R7: Entry bits 29:18 are reserved and have no effect on any response field.
- R8: `memReqValid` stays high with `memReqAddr` unchanged until `memReqReady` is seen high. The walker accepts the read data only after the request handshake.
- R9: During and right after reset, `reqReady` is 1 and `memReqValid` and `rspValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker can take a request |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | 1 for a write access, 0 for a read |
| tableBase | input | 32 | Page-table base of the current process |
| memReqValid | output | 1 | Memory read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 32 | Byte address of the table entry |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | 32 | Table entry read from memory |
| rspValid | output | 1 | Translation result present |
| rspReady | input | 1 | Requester takes the result |
| rspPaddr | output | 30 | Physical address (0 on any fault) |
| rspPageFault | output | 1 | Page is not resident |
| rspProtFault | output | 1 | Write to a read-only page |
| rspDiskLoc | output | 18 | Disk location of a non-resident page |

## Verification
The stimulus covers every kind of table entry:

- valid and writable entries, with both reads and writes;
- valid read-only entries, under a read (which must translate) and under a write (which must fault);
- invalid entries, one of them with the writable bit set, to show that the page fault wins and the disk field is passed through;
- an entry with every reserved bit set;
- the all-ones virtual address with a high table base, which checks entry address arithmetic and offset concatenation at the top of the range;
- the all-zero address with a zero base.

Memory acceptance, memory latency and requester acceptance are all stretched by varying amounts. This separates a walker that holds its handshakes correctly from one that drops or changes a request or response.

// File: rtl/pt_walk_pkg.sv
`timescale 1ns/1ps
package pt_walk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_READ_PTE  = 2'd1,
    ST_WAIT_DATA = 2'd2,
    ST_RESPOND   = 2'd3
  } walkState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureReq;
    logic captureEntry;
  } walkStrobe_t;

endpackage

// File: rtl/pw_ctrl.sv
`timescale 1ns/1ps
module pw_ctrl
  import pt_walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        rspReady,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        rspValid,
  output walkStrobe_t strobe
);

  walkState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:      if (reqValid)    stateNext = ST_READ_PTE;
      ST_READ_PTE:  if (memReqReady) stateNext = ST_WAIT_DATA;
      ST_WAIT_DATA: if (memRspValid) stateNext = ST_RESPOND;
      ST_RESPOND:   if (rspReady)    stateNext = ST_IDLE;
      default:                       stateNext = ST_IDLE;
    endcase
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_READ_PTE);
  assign rspValid    = (state == ST_RESPOND);

  assign strobe.captureReq   = (state == ST_IDLE) && reqValid;
  assign strobe.captureEntry = (state == ST_WAIT_DATA) && memRspValid;

endmodule

// File: rtl/pw_datapath.sv
`timescale 1ns/1ps
module pw_datapath
  import pt_walk_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 30,
  parameter int OFF_W = 12,
  parameter int PTE_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              reqWrite,
  input  logic [VA_W-1:0]   tableBase,
  input  logic [PTE_W-1:0]  memRspData,
  output logic [VA_W-1:0]   memReqAddr,
  output logic [PA_W-1:0]   rspPaddr,
  output logic              rspPageFault,
  output logic              rspProtFault,
  output logic [PA_W-OFF_W-1:0] rspDiskLoc
);

  localparam int VPN_W     = VA_W - OFF_W;
  localparam int PPN_W     = PA_W - OFF_W;
  localparam int PTE_SHIFT = $clog2(PTE_W / 8);
  localparam int VALID_POS = PTE_W - 1;
  localparam int WR_POS    = PTE_W - 2;

  logic [VA_W-1:0]  vaddrQ;
  logic [VA_W-1:0]  baseQ;
  logic             writeQ;
  logic [PTE_W-1:0] entryQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaddrQ <= '0;
      baseQ  <= '0;
      writeQ <= 1'b0;
    end else if (strobe.captureReq) begin
      vaddrQ <= reqVaddr;
      baseQ  <= tableBase;
      writeQ <= reqWrite;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    entryQ <= '0;
    else if (strobe.captureEntry) entryQ <= memRspData;
  end

  // Entry address: base plus page number scaled by entry size
  logic [VPN_W-1:0] vpn;
  logic [VA_W-1:0]  entryOffset;
  assign vpn         = vaddrQ[VA_W-1:OFF_W];
  assign entryOffset = {{(VA_W-VPN_W){1'b0}}, vpn} << PTE_SHIFT;
  assign memReqAddr  = baseQ + entryOffset;

  // Response decode from the captured entry
  logic             entValid, entWritable, protHit;
  logic [PPN_W-1:0] entPpn;
  assign entValid    = entryQ[VALID_POS];
  assign entWritable = entryQ[WR_POS];
  assign entPpn      = entryQ[PPN_W-1:0];
  assign protHit     = entValid && writeQ && !entWritable;

  assign rspPageFault = !entValid;
  assign rspProtFault = protHit;
  assign rspPaddr     = (entValid && !protHit) ? {entPpn, vaddrQ[OFF_W-1:0]} : '0;
  assign rspDiskLoc   = entValid ? '0 : entPpn;

endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 30,
  parameter int OFF_W = 12,
  parameter int PTE_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [VA_W-1:0]       reqVaddr,
  input  logic                  reqWrite,
  input  logic [VA_W-1:0]       tableBase,
  output logic                  memReqValid,
  input  logic                  memReqReady,
  output logic [VA_W-1:0]       memReqAddr,
  input  logic                  memRspValid,
  input  logic [PTE_W-1:0]      memRspData,
  output logic                  rspValid,
  input  logic                  rspReady,
  output logic [PA_W-1:0]       rspPaddr,
  output logic                  rspPageFault,
  output logic                  rspProtFault,
  output logic [PA_W-OFF_W-1:0] rspDiskLoc
);

  walkStrobe_t strobe;

  pw_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .rspReady    (rspReady),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .rspValid    (rspValid),
    .strobe      (strobe)
  );

  pw_datapath #(
    .VA_W (VA_W),
    .PA_W (PA_W),
    .OFF_W(OFF_W),
    .PTE_W(PTE_W)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqVaddr     (reqVaddr),
    .reqWrite     (reqWrite),
    .tableBase    (tableBase),
    .memRspData   (memRspData),
    .memReqAddr   (memReqAddr),
    .rspPaddr     (rspPaddr),
    .rspPageFault (rspPageFault),
    .rspProtFault (rspProtFault),
    .rspDiskLoc   (rspDiskLoc)
  );

endmodule

// File: rtl/pw_checker.sv
`timescale 1ns/1ps
module pw_checker #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 30,
  parameter int OFF_W = 12
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  reqValid,
  input logic                  reqReady,
  input logic                  memReqValid,
  input logic                  memReqReady,
  input logic [VA_W-1:0]       memReqAddr,
  input logic                  rspValid,
  input logic                  rspReady,
  input logic [PA_W-1:0]       rspPaddr,
  input logic                  rspPageFault,
  input logic                  rspProtFault,
  input logic [PA_W-OFF_W-1:0] rspDiskLoc
);

  assert_idle_exclusive_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!memReqValid && !rspValid));

  assert_accept_reads_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (memReqValid && !reqReady));

  assert_memreq_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  assert_rsp_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=>
      (rspValid && $stable({rspPaddr, rspPageFault, rspProtFault, rspDiskLoc})));

  assert_rsp_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspReady) |=> !rspValid);

  assert_pagefault_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspPageFault) |-> (rspPaddr == '0 && !rspProtFault));

  assert_protfault_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspProtFault) |-> (rspPaddr == '0 && rspDiskLoc == '0));

  assert_fault_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $onehot0({rspPageFault, rspProtFault}));

endmodule

bind pt_walker pw_checker #(
  .VA_W (VA_W),
  .PA_W (PA_W),
  .OFF_W(OFF_W)
) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqReady     (reqReady),
  .memReqValid  (memReqValid),
  .memReqReady  (memReqReady),
  .memReqAddr   (memReqAddr),
  .rspValid     (rspValid),
  .rspReady     (rspReady),
  .rspPaddr     (rspPaddr),
  .rspPageFault (rspPageFault),
  .rspProtFault (rspProtFault),
  .rspDiskLoc   (rspDiskLoc)
);

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqReady, reqWrite;
  logic [31:0] reqVaddr, tableBase;
  logic        memReqValid, memReqReady;
  logic [31:0] memReqAddr;
  logic        memRspValid;
  logic [31:0] memRspData;
  logic        rspValid, rspReady;
  logic [29:0] rspPaddr;
  logic        rspPageFault, rspProtFault;
  logic [17:0] rspDiskLoc;

  always #4 clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr),
    .reqWrite(reqWrite), .tableBase(tableBase),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .rspValid(rspValid), .rspReady(rspReady), .rspPaddr(rspPaddr),
    .rspPageFault(rspPageFault), .rspProtFault(rspProtFault), .rspDiskLoc(rspDiskLoc)
  );

  int vecCount  = 0;
  int missCount = 0;
  int doneCount = 0;
  int memTurn   = 0;
  int rspTurn   = 0;
  localparam int NUM_VEC = 9;

  logic [31:0] memAddrQ[$];
  logic [31:0] pteQ[$];
  logic [29:0] expPaddrQ[$];
  bit          expPfQ[$];
  bit          expPrQ[$];
  logic [17:0] expDiskQ[$];
  string       tagQ[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    vecCount++;
    if (!ok) begin
      missCount++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: computes expected result and pushes it into the scoreboard
  task automatic translate(input logic [31:0] va, input bit wr,
                           input logic [31:0] base, input logic [31:0] pte,
                           input string tag);
    bit          vld = pte[31];
    bit          wrOk = pte[30];
    bit          pf = !vld;
    bit          pr = vld && wr && !wrOk;
    logic [29:0] pa = (vld && !pr) ? {pte[17:0], va[11:0]} : 30'd0;
    memAddrQ.push_back(base + {10'd0, va[31:12], 2'b00});
    pteQ.push_back(pte);
    expPaddrQ.push_back(pa);
    expPfQ.push_back(pf);
    expPrQ.push_back(pr);
    expDiskQ.push_back(pf ? pte[17:0] : 18'd0);
    tagQ.push_back(tag);
    while (!reqReady) @(negedge clk);
    reqVaddr  = va;
    reqWrite  = wr;
    tableBase = base;
    reqValid  = 1'b1;
    @(negedge clk);
    reqValid  = 1'b0;
    tableBase = ~base;            // R2: later base changes must not matter
    reqVaddr  = 32'h5A5A_5A5A;
    check(reqReady == 1'b0, "R1", "ready low while busy", reqReady, 0);
  endtask

  // Memory model
  initial begin
    memReqReady = 1'b0;
    memRspValid = 1'b0;
    memRspData  = 32'hFFFF_FFFF;
    forever begin
      @(negedge clk);
      if (memReqValid && rstN) begin
        if (memAddrQ.size() == 0) begin
          check(1'b0, "R2", "unexpected memory read", memReqAddr, 0);
        end else begin
          check(memReqAddr == memAddrQ[0], "R2", "entry address", memReqAddr, memAddrQ[0]);
          repeat (memTurn % 3) begin
            @(negedge clk);
            check(memReqValid && memReqAddr == memAddrQ[0], "R8", "request held",
                  {memReqValid, memReqAddr}, {1'b1, memAddrQ[0]});
          end
          memReqReady = 1'b1;
          @(negedge clk);
          memReqReady = 1'b0;
          check(!memReqValid, "R2", "single read", memReqValid, 0);
          repeat (memTurn % 2) begin
            @(negedge clk);
            check(!memReqValid, "R8", "no read while waiting", memReqValid, 0);
          end
          memRspData  = pteQ.pop_front();
          memRspValid = 1'b1;
          void'(memAddrQ.pop_front());
          @(negedge clk);
          memRspValid = 1'b0;
          memRspData  = 32'hFFFF_FFFF;
          memTurn++;
        end
      end
    end
  end

  // Response monitor: pops the scoreboard and compares
  initial begin
    rspReady = 1'b0;
    forever begin
      @(negedge clk);
      if (rspValid && rstN) begin
        if (expPaddrQ.size() == 0) begin
          check(1'b0, "R1", "unexpected response", rspPaddr, 0);
        end else begin
          check(rspPaddr == expPaddrQ[0], tagQ[0], "paddr", rspPaddr, expPaddrQ[0]);
          check(rspPageFault == expPfQ[0], tagQ[0], "page fault", rspPageFault, expPfQ[0]);
          check(rspProtFault == expPrQ[0], tagQ[0], "prot fault", rspProtFault, expPrQ[0]);
          check(rspDiskLoc == expDiskQ[0], tagQ[0], "disk loc", rspDiskLoc, expDiskQ[0]);
          repeat (rspTurn % 3) begin
            @(negedge clk);
            check(rspValid && rspPaddr == expPaddrQ[0] && rspPageFault == expPfQ[0]
                  && rspProtFault == expPrQ[0] && rspDiskLoc == expDiskQ[0],
                  "R6", "response held", {rspValid, rspPaddr}, {1'b1, expPaddrQ[0]});
          end
          rspReady = 1'b1;
          @(negedge clk);
          rspReady = 1'b0;
          check(!rspValid, "R6", "drop after take", rspValid, 0);
          void'(expPaddrQ.pop_front());
          void'(expPfQ.pop_front());
          void'(expPrQ.pop_front());
          void'(expDiskQ.pop_front());
          void'(tagQ.pop_front());
          rspTurn++;
          doneCount++;
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", doneCount, NUM_VEC);
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    rstN      = 1'b0;
    reqValid  = 1'b0;
    reqWrite  = 1'b0;
    reqVaddr  = '0;
    tableBase = '0;
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1, "R9", "reset reqReady", reqReady, 1);
    check(memReqValid == 1'b0, "R9", "reset memReqValid", memReqValid, 0);
    check(rspValid == 1'b0, "R9", "reset rspValid", rspValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !memReqValid && !rspValid, "R9", "after reset",
          {reqReady, memReqValid, rspValid}, 3'b100);

    translate(32'h1234_5ABC, 1'b0, 32'h0010_0000, 32'hC000_2A5F, "R3");
    translate(32'h0040_1007, 1'b1, 32'h0020_0000, 32'hC001_0001, "R3");
    translate(32'h7FFF_E123, 1'b0, 32'h0030_0000, 32'h8000_0ABC, "R5");
    translate(32'h7FFF_E123, 1'b1, 32'h0030_0000, 32'h8000_0ABC, "R5");
    translate(32'h0ABC_D000, 1'b0, 32'h0100_0000, 32'h0003_1234, "R4");
    translate(32'h0ABC_DFFF, 1'b1, 32'h0100_0000, 32'h4001_0FFF, "R4");
    translate(32'h0000_3456, 1'b0, 32'h0000_4000, 32'hBFFC_0007, "R7");
    translate(32'hFFFF_FFFF, 1'b0, 32'h8000_0000, 32'hC003_FFFF, "R3");
    translate(32'h0000_0000, 1'b1, 32'h0000_0000, 32'hC000_0000, "R3");

    while (doneCount < NUM_VEC) @(negedge clk);
    repeat (2) @(negedge clk);
    check(reqReady && !memReqValid && !rspValid, "R1", "idle at end",
          {reqReady, memReqValid, rspValid}, 3'b100);
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

endmodule